// File: doc/BRIEF.md
# Configurable SPI Master Word Engine

This block is an SPI bus master. Software pushes transaction words into a four-entry transmit queue. The engine then shifts each word out on MOSI and collects the same number of bits from MISO into a receive register. When a word completes, the engine sets a sticky done flag. The serial clock is derived from the system clock through a programmable divider. Its idle level, the edge that launches MOSI and the edge that samples MISO are each selectable.

Several properties are configurable per transfer: the word length (1 to 32 bits), the bit order, and a gap between consecutive words counted in half serial-clock periods. An optional automatic slave-select mode drives the active-low select line from the engine state. In that mode a long gap releases the select between words, and a short gap keeps it asserted until the queue drains. With the automatic mode off, the select line follows a software bit.

Top module: `spi_word_master`

## Requirements
- R1: When no word is in progress, `sclk` equals `cfg_cpol`: 1 gives an idle-high clock, 0 gives an idle-low clock.
- R2: MOSI changes only on the transmit edge, which is falling when `cfg_tx_fall`=1 and rising when 0. MISO is sampled on the receive edge, which is falling when `cfg_rx_fall`=1 and rising when 0. Correct operation requires `cfg_tx_fall` and `cfg_rx_fall` to differ.
- R3: A word takes N full `sclk` periods (2N edges), where N is `cfg_wlen`, with value 0 meaning 32. Each `sclk` half period lasts `cfg_div`+1 system clocks.
- R4: With `cfg_lsb_first`=1, bit 0 of a word goes out first and the first received bit lands in `rx_data` bit 0. With `cfg_lsb_first`=0, bit N-1 goes first in both directions. Received bits above N-1 read as 0.
- R5: `unit_done` goes to 1 when the last edge of a word occurs, and `rx_data` holds that word from then on. The flag stays 1 until `done_clr` is pulsed.
- R6: When a further word is queued, the time from the last `sclk` edge of one word to the first edge of the next is (2·`cfg_gap`+1)·(`cfg_div`+1) system clocks, that is `cfg_gap`+0.5 serial periods.
- R7: With `cfg_auto_ss`=1, `ss_n` goes low when a word starts out of an empty queue. It returns high once the queue and the shifter are both empty.
- R8: With `cfg_auto_ss`=1 and `cfg_gap`≥3, `ss_n` is high during every inter-word gap. With `cfg_gap`<3, it stays low from the first word to the last.
- R9: With `cfg_auto_ss`=0, `ss_n` equals the inverse of `cfg_ss_on` whatever the engine is doing.
- R10: The queue holds 4 words. `tx_full` and `tx_empty` report its state, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_tx_fall | input | 1 | 1: MOSI launched on falling edge |
| cfg_rx_fall | input | 1 | 1: MISO sampled on falling edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_wlen | input | 5 | Word length, 0 means 32 |
| cfg_gap | input | 4 | Inter-word gap, value+0.5 serial periods |
| cfg_div | input | 8 | Half period minus one, in system clocks |
| cfg_auto_ss | input | 1 | Select line driven by the engine |
| cfg_ss_on | input | 1 | Select request when automatic mode is off |
| tx_push | input | 1 | Write `tx_data` into the queue |
| tx_data | input | 32 | Word to send |
| tx_full | output | 1 | Queue holds 4 words |
| tx_empty | output | 1 | Queue holds no words |
| rx_data | output | 32 | Last received word |
| unit_done | output | 1 | Sticky word-complete flag |
| done_clr | input | 1 | Clears `unit_done` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A wrong edge counter or a bad bit-order index shows up within one word, as a misplaced or missing bit in the word seen on MOSI or in `rx_data`. A bad clock phase state leaves `sclk` at the wrong level once the engine goes idle. A wrong gap counter shifts the first edge of the second word by at least one half period. It can also release or hold `ss_n` in that gap contrary to the gap threshold, so it is visible before the second word starts. A corrupt queue count appears within a few pushes as a dropped, repeated or extra word.

// File: rtl/spiw_pkg.sv
// Shared types for the SPI word engine.
package spiw_pkg;
    // Engine phase: waiting for data, shifting a word, or timing the inter-word gap.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } spiw_state_e;
endpackage

// File: rtl/spiw_fifo.sv
// Transmit word queue.
// Assumes: a push while full is dropped, even when a pop happens in the same cycle;
// a pop while empty is ignored. The read data shows the oldest entry.
module spiw_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    // Accept only legal operations.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        rdata   = mem[rd_ptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full) else $error("queue overflow"); // R10
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)) else $error("full and empty together"); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty) else $error("queue underflow"); // R10
endmodule

// File: rtl/spiw_tick.sv
// Half-period tick generator for the serial clock.
// Assumes: div is held constant while en is high. Emits one pulse every div+1 cycles,
// and the count restarts whenever en is low.
module spiw_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Pulse on the terminal count.
    always_comb tick = en && (cnt == div);

    // Divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt == div) cnt <= '0;
        else cnt <= cnt + DIV_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick) else $error("tick too close"); // R3
endmodule

// File: rtl/spiw_shifter.sv
// Word shifter and sequencer: loads words from the queue, toggles the clock phase on
// each tick, launches and samples bits on the configured edges, times the inter-word gap
// and drives the slave select.
// Assumes: DATA_W is a power of two; tx and rx edge selects differ; configuration is
// held stable while busy.
module spiw_shifter
    import spiw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int GAP_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      cfg_cpol,
    input  logic                      cfg_tx_fall,
    input  logic                      cfg_rx_fall,
    input  logic                      cfg_lsb_first,
    input  logic [$clog2(DATA_W)-1:0] cfg_wlen,
    input  logic [GAP_W-1:0]          cfg_gap,
    input  logic                      cfg_auto_ss,
    input  logic                      cfg_ss_on,
    input  logic                      fifo_empty,
    input  logic [DATA_W-1:0]         fifo_rdata,
    output logic                      fifo_pop,
    output logic                      busy,
    input  logic                      done_clr,
    output logic [DATA_W-1:0]         rx_data,
    output logic                      unit_done,
    output logic                      sclk,
    output logic                      mosi,
    input  logic                      miso,
    output logic                      ss_n
);
    localparam int LW = $clog2(DATA_W);
    localparam int KW = LW + 1;
    localparam int GW = GAP_W + 1;

    spiw_state_e       state;
    logic              lvl;
    logic [KW-1:0]     k, last_k;
    logic [DATA_W-1:0] sr, sr_shifted, rx_sr, rx_next;
    logic [LW-1:0]     rcnt, msb_pos, rx_pos;
    logic [GW-1:0]     gcnt, gap_end;
    logic              edge_now, rising, is_tx, is_rx, do_shift;
    logic              word_end, gap_done, gap_short, load;

    // Decode the current edge and the next actions.
    always_comb begin
        msb_pos    = cfg_wlen - LW'(1);
        last_k     = {msb_pos, 1'b1};
        gap_end    = {cfg_gap, 1'b0} - GW'(1);
        gap_short  = (cfg_gap < GAP_W'(3));
        edge_now   = (state == ST_SHIFT) && tick;
        rising     = cfg_cpol ^ ~lvl;
        is_tx      = edge_now && (rising ^ cfg_tx_fall);
        is_rx      = edge_now && (rising ^ cfg_rx_fall);
        word_end   = edge_now && (k == last_k);
        do_shift   = is_tx && (k != '0) && !word_end;
        gap_done   = (state == ST_GAP) && tick && (gcnt == gap_end);
        load       = !fifo_empty && ((state == ST_IDLE) || (word_end && cfg_gap == '0) || gap_done);
        sr_shifted = cfg_lsb_first ? (sr >> 1) : (sr << 1);
        rx_pos     = cfg_lsb_first ? rcnt : (msb_pos - rcnt);
        rx_next    = rx_sr;
        if (is_rx) rx_next[rx_pos] = miso;
    end

    // Sequencer, clock phase and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lvl   <= 1'b0;
            k     <= '0;
            sr    <= '0;
            rx_sr <= '0;
            rcnt  <= '0;
            gcnt  <= '0;
        end else if (load) begin
            state <= ST_SHIFT;
            lvl   <= 1'b0;
            k     <= '0;
            sr    <= fifo_rdata;
            rx_sr <= '0;
            rcnt  <= '0;
            gcnt  <= '0;
        end else begin
            case (state)
                ST_SHIFT: begin
                    if (edge_now) begin
                        lvl   <= ~lvl;
                        k     <= k + KW'(1);
                        rx_sr <= rx_next;
                        if (is_rx) rcnt <= rcnt + LW'(1);
                        if (do_shift) sr <= sr_shifted;
                        if (word_end) begin
                            state <= (cfg_gap == '0) ? ST_IDLE : ST_GAP;
                            gcnt  <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        gcnt <= gcnt + GW'(1);
                        if (gcnt == gap_end) state <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Received word and sticky done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            unit_done <= 1'b0;
        end else begin
            if (word_end) rx_data <= rx_next;
            if (word_end) unit_done <= 1'b1;
            else if (done_clr) unit_done <= 1'b0;
        end
    end

    // Serial pins and handshake to the queue and divider.
    always_comb begin
        sclk     = cfg_cpol ^ lvl;
        mosi     = (state == ST_IDLE) ? 1'b0 : (cfg_lsb_first ? sr[0] : sr[msb_pos]);
        ss_n     = cfg_auto_ss ? !((state == ST_SHIFT) || ((state == ST_GAP) && gap_short))
                               : !cfg_ss_on;
        busy     = (state != ST_IDLE);
        fifo_pop = load;
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sclk == cfg_cpol)) else $error("idle clock level"); // R1
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state == ST_SHIFT) && !$past(is_tx) && !$past(load))
        |-> $stable(mosi)) else $error("mosi moved off the transmit edge"); // R2
    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (k <= last_k)) else $error("edge count overrun"); // R3
    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && $stable(cfg_cpol)) |-> $stable(sclk)) else $error("clock moved without tick"); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && !done_clr) |=> unit_done) else $error("done flag dropped"); // R5
    AST_SS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_ss && $stable(cfg_auto_ss) && $fell(ss_n)) |-> (state == ST_SHIFT && k == '0))
        else $error("select asserted outside word start"); // R7
endmodule

// File: rtl/spi_word_master.sv
// SPI master word engine top: queue, divider and shifter.
// Assumes: configuration inputs change only while the engine is idle and the queue empty.
module spi_word_master #(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8,
    parameter int GAP_W      = 4,
    localparam int LW        = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_tx_fall,
    input  logic              cfg_rx_fall,
    input  logic              cfg_lsb_first,
    input  logic [LW-1:0]     cfg_wlen,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_auto_ss,
    input  logic              cfg_ss_on,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              unit_done,
    input  logic              done_clr,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    logic              pop, busy, tick;
    logic [DATA_W-1:0] head;

    spiw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data), .pop(pop),
        .rdata(head), .full(tx_full), .empty(tx_empty)
    );

    spiw_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(busy), .div(cfg_div), .tick(tick)
    );

    spiw_shifter #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_cpol(cfg_cpol), .cfg_tx_fall(cfg_tx_fall), .cfg_rx_fall(cfg_rx_fall),
        .cfg_lsb_first(cfg_lsb_first), .cfg_wlen(cfg_wlen), .cfg_gap(cfg_gap),
        .cfg_auto_ss(cfg_auto_ss), .cfg_ss_on(cfg_ss_on),
        .fifo_empty(tx_empty), .fifo_rdata(head), .fifo_pop(pop), .busy(busy),
        .done_clr(done_clr), .rx_data(rx_data), .unit_done(unit_done),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );
endmodule

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_cpol = 0, cfg_tx_fall = 1, cfg_rx_fall = 0, cfg_lsb_first = 0;
    logic [4:0] cfg_wlen = 5'd8;
    logic [3:0] cfg_gap = 4'd3;
    logic [7:0] cfg_div = 8'd1;
    logic cfg_auto_ss = 1, cfg_ss_on = 0;
    logic tx_push = 0, done_clr = 0, miso = 0;
    logic [31:0] tx_data = '0;
    logic tx_full, tx_empty, unit_done, sclk, mosi, ss_n;
    logic [31:0] rx_data;

    int checks = 0, fails = 0;
    bit mon_on = 0;
    int ne = 0, nb = 0, ss_rises = 0;
    longint edge_t [0:511];
    bit mo_bits [0:511];
    bit mi_bits [0:511];

    spi_word_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_tx_fall(cfg_tx_fall),
        .cfg_rx_fall(cfg_rx_fall), .cfg_lsb_first(cfg_lsb_first), .cfg_wlen(cfg_wlen),
        .cfg_gap(cfg_gap), .cfg_div(cfg_div), .cfg_auto_ss(cfg_auto_ss), .cfg_ss_on(cfg_ss_on),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_data(rx_data), .unit_done(unit_done), .done_clr(done_clr),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #(CLK_P/2) clk = ~clk;

    // Serial-side slave model: logs edges, captures MOSI and drives MISO on receive edges.
    always @(sclk) begin
        if (mon_on) begin
            if (ne < 511) begin edge_t[ne] = $time; ne++; end
            if (sclk ^ cfg_rx_fall) begin
                if (nb < 511) begin mo_bits[nb] = mosi; nb++; end
                #1 miso = mi_bits[nb];
            end
        end
    end

    always @(posedge ss_n) if (mon_on) ss_rises++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] asm_word(input int start, input int n, input bit lsb);
        logic [31:0] w = '0;
        for (int i = 0; i < n; i++) begin
            if (lsb) w[i] = mo_bits[start + i];
            else     w[n - 1 - i] = mo_bits[start + i];
        end
        return w;
    endfunction

    task automatic mon_reset();
        ne = 0; nb = 0; ss_rises = 0;
        for (int i = 0; i < 512; i++) mi_bits[i] = 1'b0;
    endtask

    task automatic clear_done();
        done_clr = 1; @(negedge clk); done_clr = 0;
    endtask

    task automatic wait_bits(input int target);
        for (int i = 0; i < 20000 && nb < target; i++) @(negedge clk);
    endtask

    // One word in a given mode; checks MOSI word, received word, flag, timing, idle pins.
    task automatic xfer(input bit cp, input bit txf, input bit rxf, input bit lsb,
                        input logic [4:0] wl, input logic [7:0] dv, input logic [3:0] gp,
                        input logic [31:0] txw, input logic [31:0] rxw);
        int n = (wl == 0) ? 32 : int'(wl);
        logic [31:0] mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        @(negedge clk);
        cfg_cpol = cp; cfg_tx_fall = txf; cfg_rx_fall = rxf; cfg_lsb_first = lsb;
        cfg_wlen = wl; cfg_div = dv; cfg_gap = gp; cfg_auto_ss = 1;
        clear_done();
        chk(sclk == cp, "R1 idle level before word", {31'd0, sclk}, {31'd0, cp});
        mon_reset();
        for (int i = 0; i < n; i++) mi_bits[i] = lsb ? rxw[i] : rxw[n - 1 - i];
        miso = mi_bits[0];
        mon_on = 1;
        tx_push = 1; tx_data = txw; @(negedge clk); tx_push = 0;
        for (int i = 0; i < 20000 && !unit_done; i++) @(negedge clk);
        repeat ((2 * int'(gp) + 3) * (int'(dv) + 1) + 4) @(negedge clk);
        chk(asm_word(0, n, lsb) == (txw & mask), "R4 R2 mosi word", asm_word(0, n, lsb), txw & mask);
        chk(rx_data == (rxw & mask), "R4 R2 received word", rx_data, rxw & mask);
        chk(unit_done == 1'b1, "R5 done flag held", {31'd0, unit_done}, 32'd1);
        chk(ne == 2 * n, "R3 edges per word", ne, 2 * n);
        chk((edge_t[1] - edge_t[0]) / CLK_P == longint'(dv) + 1, "R3 half period",
            32'((edge_t[1] - edge_t[0]) / CLK_P), 32'(dv) + 32'd1);
        chk(sclk == cp, "R1 idle level after word", {31'd0, sclk}, {31'd0, cp});
        chk(ss_n == 1'b1, "R7 select released when idle", {31'd0, ss_n}, 32'd1);
        mon_on = 0;
    endtask

    // Two or more 4-bit words back to back: gap timing and select behaviour.
    task automatic gap_test(input logic [3:0] gp, input int nw);
        logic [31:0] w [0:3];
        @(negedge clk);
        cfg_cpol = 0; cfg_tx_fall = 1; cfg_rx_fall = 0; cfg_lsb_first = 0;
        cfg_wlen = 5'd4; cfg_div = 8'd1; cfg_gap = gp; cfg_auto_ss = 1;
        mon_reset(); miso = 0; mon_on = 1;
        for (int j = 0; j < nw; j++) begin
            w[j] = 32'((j * 5 + 3) & 15);
            tx_push = 1; tx_data = w[j]; @(negedge clk);
        end
        tx_push = 0;
        wait_bits(4 * nw);
        repeat ((2 * int'(gp) + 3) * 2 + 6) @(negedge clk);
        chk((edge_t[8] - edge_t[7]) / CLK_P == (2 * longint'(gp) + 1) * 2, "R6 gap length",
            32'((edge_t[8] - edge_t[7]) / CLK_P), (2 * 32'(gp) + 32'd1) * 32'd2);
        chk(asm_word(4, 4, 0) == w[1], "R6 second word after gap", asm_word(4, 4, 0), w[1]);
        chk(ss_rises == ((gp >= 3) ? nw : 1), "R8 select releases", ss_rises, (gp >= 3) ? nw : 1);
        chk(ss_n == 1'b1, "R7 select released after last word", {31'd0, ss_n}, 32'd1);
        mon_on = 0;
    endtask

    // Fill the queue, push once more while full, count words sent.
    task automatic full_test();
        logic [31:0] w [0:4];
        w[0] = 32'hA; w[1] = 32'h3; w[2] = 32'hC; w[3] = 32'h5; w[4] = 32'h6;
        @(negedge clk);
        cfg_cpol = 0; cfg_tx_fall = 1; cfg_rx_fall = 0; cfg_lsb_first = 0;
        cfg_wlen = 5'd4; cfg_div = 8'd1; cfg_gap = 4'd0; cfg_auto_ss = 1;
        mon_reset(); miso = 0; mon_on = 1;
        for (int j = 0; j < 5; j++) begin
            tx_push = 1; tx_data = w[j]; @(negedge clk);
        end
        chk(tx_full == 1'b1, "R10 full after five pushes", {31'd0, tx_full}, 32'd1);
        tx_data = 32'hF; @(negedge clk); tx_push = 0;
        wait_bits(24);
        repeat (40) @(negedge clk);
        chk(nb == 20, "R10 dropped push while full", nb, 20);
        chk(asm_word(16, 4, 0) == w[4], "R10 last word sent", asm_word(16, 4, 0), w[4]);
        chk(tx_empty == 1'b1, "R10 empty after drain", {31'd0, tx_empty}, 32'd1);
        chk(ss_rises == 1, "R8 short gap holds select", ss_rises, 1);
        mon_on = 0;
    endtask

    task automatic done_test();
        chk(unit_done == 1'b1, "R5 flag set before clear", {31'd0, unit_done}, 32'd1);
        clear_done();
        chk(unit_done == 1'b0, "R5 flag cleared", {31'd0, unit_done}, 32'd0);
    endtask

    task automatic manual_test();
        @(negedge clk);
        cfg_auto_ss = 0; cfg_ss_on = 1; cfg_wlen = 5'd4; cfg_div = 8'd0; cfg_gap = 4'd4;
        @(negedge clk);
        chk(ss_n == 1'b0, "R9 forced select on", {31'd0, ss_n}, 32'd0);
        clear_done();
        tx_push = 1; tx_data = 32'h9; @(negedge clk); tx_push = 0;
        for (int i = 0; i < 2000 && !unit_done; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(ss_n == 1'b0, "R9 select held by software after word", {31'd0, ss_n}, 32'd0);
        cfg_ss_on = 0; @(negedge clk);
        chk(ss_n == 1'b1, "R9 forced select off", {31'd0, ss_n}, 32'd1);
        cfg_auto_ss = 1;
    endtask

    task automatic reset_test();
        chk(ss_n == 1'b1, "R7 reset select", {31'd0, ss_n}, 32'd1);
        chk(sclk == 1'b0, "R1 reset clock level", {31'd0, sclk}, 32'd0);
        chk(tx_empty == 1'b1 && tx_full == 1'b0, "R10 reset flags", {30'd0, tx_full, tx_empty}, 32'd1);
        chk(unit_done == 1'b0, "R5 reset flag", {31'd0, unit_done}, 32'd0);
        chk(rx_data == 32'd0, "R5 reset data", rx_data, 32'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        reset_test();
        xfer(0, 1, 0, 0, 5'd8,  8'd2, 4'd3, 32'h0000_00A5, 32'h0000_003C);
        done_test();
        xfer(1, 0, 1, 1, 5'd12, 8'd0, 4'd0, 32'h0000_0ABC, 32'h0000_05A3);
        xfer(0, 0, 1, 0, 5'd0,  8'd1, 4'd2, 32'hDEAD_BEEF, 32'h1234_5678);
        xfer(1, 1, 0, 1, 5'd1,  8'd3, 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        xfer(0, 1, 0, 1, 5'd7,  8'd1, 4'd0, 32'h0000_0F4B, 32'h0000_0F16);
        gap_test(4'd3, 2);
        gap_test(4'd1, 3);
        gap_test(4'd15, 2);
        gap_test(4'd0, 2);
        full_test();
        manual_test();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule